// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous memory with two ports, left and right. Both ports can reach every word of one shared array, and both can do so in the same clock cycle. Each port has its own enable, write select, output enable, address, write data, read data and an active-low interrupt. A port acts only in a cycle where its enable is high. In that cycle a high write select makes it a write; a low write select makes it a read. Read data comes from a register that is loaded by the read, so the word appears one cycle after the read is issued.

The two highest addresses carry messages between the two sides. Address all-ones is the right side's mailbox. Address all-ones-except-bit-0 is the left side's mailbox. When a side writes into the other side's mailbox, the owner's interrupt goes low. The owner releases it by reading its own mailbox. The message is ordinary data, held in the array like any other word. Software on each side can use this as a doorbell.

Top module: `dpr_mailbox_ram`

## Requirements
- R1: A word written through either port at any address is returned by a later read of that address on either port. The read data appears on the read-data output in the cycle after the read.
- R2: Both ports may operate in the same cycle, including both reading the same address, and each port returns its own word.
- R3: When both ports write the same address in the same cycle, the left port's data is stored.
- R4: When one port writes an address while the other port reads it in the same cycle, the reader receives the word held before that write.
- R5: While a port's enable is low, it writes nothing and its held read data does not change, whatever its other inputs are.
- R6: The read-data output is all zeros while that port's output enable is low. While the output enable is high, the output shows the word from that port's most recent read.
- R7: A left-port write to address all-ones drives the right interrupt low from the next cycle on.
- R8: A right-port write to address all-ones-minus-one (bit 0 clear, all other bits set) drives the left interrupt low from the next cycle on.
- R9: A read by a port of its own mailbox returns the stored message. It releases that port's interrupt (high), and the release is visible in the same cycle as the returned data.
- R10: A read by a port of the other port's mailbox returns its contents and leaves both interrupts unchanged.
- R11: A write by a port into its own mailbox stores the data and leaves both interrupts unchanged.
- R12: If a set and a release of the same interrupt occur in the same cycle, the interrupt stays asserted.
- R13: After a synchronous reset (rst_n low at a clock edge), both interrupts are high and both read-data registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write select (1 = write, 0 = read) |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | AW | Left port address |
| l_wdata | input | DW | Left port write data |
| l_rdata | output | DW | Left port read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write select (1 = write, 0 = read) |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | AW | Right port address |
| r_wdata | input | DW | Right port write data |
| r_rdata | output | DW | Right port read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds the block with its default parameters: an 8-bit address and 16-bit data. At this size both mailboxes (0xFF and 0xFE) sit next to ordinary words in a small array, and a reference array in the bench can mirror the whole memory. With that mirror, every same-cycle combination is checked directly against stored contents: two writes to one word, a write racing a read, and a set racing a release of one interrupt.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  function automatic port_op_e op_of(input logic en, input logic wr);
    if (!en) return OP_IDLE;
    return wr ? OP_WRITE : OP_READ;
  endfunction

  // A set and a release in the same cycle: the set is kept.
  function automatic logic flag_next(input logic set, input logic clr,
                                     input logic cur);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_we,
  input  logic          l_re,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rq,
  input  logic          r_we,
  input  logic          r_re,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rq
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Left is written last, so it takes the word on a same-address collision.
  always_ff @(posedge clk) begin
    if (r_we) mem[r_addr] <= r_wdata;
    if (l_we) mem[l_addr] <= l_wdata;
  end

  // Nonblocking reads return the word held before any write in this cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rq <= '0;
      r_rq <= '0;
    end else begin
      if (l_re) l_rq <= mem[l_addr];
      if (r_re) r_rq <= mem[r_addr];
    end
  end

  // R5
  l_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_re |=> $stable(l_rq));

  // R5
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_re |=> $stable(r_rq));

endmodule

// File: rtl/dpr_mbox.sv
module dpr_mbox #(
  parameter int              AW  = 8,
  parameter logic [AW-1:0]   BOX = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          peer_we,
  input  logic [AW-1:0] peer_addr,
  input  logic          own_re,
  input  logic [AW-1:0] own_addr,
  output logic          irq_n
);
  import dpr_pkg::*;

  logic set_ev;
  logic clr_ev;
  logic flag_q;

  assign set_ev = peer_we && (peer_addr == BOX);
  assign clr_ev = own_re  && (own_addr  == BOX);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(set_ev, clr_ev, flag_q);
  end

  assign irq_n = ~flag_q;

  // R7 R8 R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> !irq_n);

  // R9
  own_read_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> irq_n);

  // R10 R11
  no_event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_ev && !clr_ev) |=> $stable(irq_n));

endmodule

// File: rtl/dpr_mailbox_ram.sv
module dpr_mailbox_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq_n,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_irq_n
);
  import dpr_pkg::*;

  localparam logic [AW-1:0] BOX_R = '1;
  localparam logic [AW-1:0] BOX_L = {{(AW-1){1'b1}}, 1'b0};

  port_op_e l_op, r_op;
  logic l_we, l_re, r_we, r_re;
  logic [DW-1:0] l_rq, r_rq;

  assign l_op = op_of(l_en, l_wr);
  assign r_op = op_of(r_en, r_wr);
  assign l_we = (l_op == OP_WRITE);
  assign l_re = (l_op == OP_READ);
  assign r_we = (r_op == OP_WRITE);
  assign r_re = (r_op == OP_READ);

  dpr_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .l_we(l_we), .l_re(l_re), .l_addr(l_addr), .l_wdata(l_wdata), .l_rq(l_rq),
    .r_we(r_we), .r_re(r_re), .r_addr(r_addr), .r_wdata(r_wdata), .r_rq(r_rq)
  );

  // Side 0 is owned by the left port, side 1 by the right port.
  logic [1:0]         own_re, peer_we, irq_n_v;
  logic [1:0][AW-1:0] own_addr, peer_addr;

  assign own_re    = {r_re, l_re};
  assign own_addr  = {r_addr, l_addr};
  assign peer_we   = {l_we, r_we};
  assign peer_addr = {l_addr, r_addr};

  for (genvar g = 0; g < 2; g++) begin : gen_side
    localparam logic [AW-1:0] BOX = (g == 0) ? BOX_L : BOX_R;
    dpr_mbox #(.AW(AW), .BOX(BOX)) u_mbox (
      .clk(clk), .rst_n(rst_n),
      .peer_we(peer_we[g]), .peer_addr(peer_addr[g]),
      .own_re(own_re[g]), .own_addr(own_addr[g]),
      .irq_n(irq_n_v[g])
    );
  end

  assign l_irq_n = irq_n_v[0];
  assign r_irq_n = irq_n_v[1];
  assign l_rdata = l_oe ? l_rq : '0;
  assign r_rdata = r_oe ? r_rq : '0;

  // R13
  reset_irq_chk: assert property (@(posedge clk)
    !rst_n |=> (l_irq_n && r_irq_n));

endmodule

// File: tb/dpr_mailbox_ram_tb.sv
`timescale 1ns/1ps
module dpr_mailbox_ram_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] BR = 8'hFF;
  localparam logic [AW-1:0] BL = 8'hFE;

  logic clk = 1'b0;
  logic rst_n;
  logic l_en, l_wr, l_oe, r_en, r_wr, r_oe;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  always #2 clk = ~clk;

  dpr_mailbox_ram #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  typedef struct {
    string         tag;
    logic [DW-1:0] ld, rd;
    logic          li, ri;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [DW-1:0] model [1 << AW];
  logic [DW-1:0] m_lrq, m_rrq;
  logic m_lf, m_rf;

  task automatic cmp(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "l_rdata", l_rdata, e.ld);
      cmp(e.tag, "r_rdata", r_rdata, e.rd);
      cmp(e.tag, "l_irq_n", {{(DW-1){1'b0}}, l_irq_n}, {{(DW-1){1'b0}}, e.li});
      cmp(e.tag, "r_irq_n", {{(DW-1){1'b0}}, r_irq_n}, {{(DW-1){1'b0}}, e.ri});
    end
  end

  task automatic step(string tag, logic rst,
                      logic le, logic lw, logic lo, logic [AW-1:0] la, logic [DW-1:0] ld,
                      logic re, logic rw, logic ro, logic [AW-1:0] ra, logic [DW-1:0] rd);
    exp_t e;
    logic lrd, rrd, lwe, rwe, sl, sr, cl, cr;
    @(negedge clk); #1;
    rst_n = rst; l_en = le; l_wr = lw; l_oe = lo; l_addr = la; l_wdata = ld;
    r_en = re; r_wr = rw; r_oe = ro; r_addr = ra; r_wdata = rd;
    lrd = le && !lw; lwe = le && lw; rrd = re && !rw; rwe = re && rw;
    if (!rst) begin
      m_lrq = '0; m_rrq = '0; m_lf = 0; m_rf = 0;
    end else begin
      sr = lwe && (la == BR); cr = rrd && (ra == BR);
      sl = rwe && (ra == BL); cl = lrd && (la == BL);
      if (lrd) m_lrq = model[la];
      if (rrd) m_rrq = model[ra];
      m_rf = sr ? 1'b1 : (cr ? 1'b0 : m_rf);
      m_lf = sl ? 1'b1 : (cl ? 1'b0 : m_lf);
    end
    if (rwe) model[ra] = rd;
    if (lwe) model[la] = ld;
    e.tag = tag;
    e.ld = lo ? m_lrq : '0;
    e.rd = ro ? m_rrq : '0;
    e.li = ~m_lf;
    e.ri = ~m_rf;
    q.push_back(e);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; l_en = 0; l_wr = 0; l_oe = 0; l_addr = '0; l_wdata = '0;
    r_en = 0; r_wr = 0; r_oe = 0; r_addr = '0; r_wdata = '0;
    m_lrq = '0; m_rrq = '0; m_lf = 0; m_rf = 0;
    // R13 reset state
    step("R13", 0, 0,0,1,0,0, 0,0,1,0,0);
    step("R13", 0, 0,0,1,0,0, 0,0,1,0,0);
    step("R13", 1, 0,0,1,0,0, 0,0,1,0,0);
    // R1 writes on both ports, then cross reads
    step("R1", 1, 1,1,1,8'h05,16'hA5A5, 1,1,1,8'h09,16'h5A5A);
    step("R1", 1, 1,0,1,8'h09,0, 1,0,1,8'h05,0);
    step("R1", 1, 0,0,1,0,0, 0,0,1,0,0);
    // R6 output enable low gives zero, high again shows held word
    step("R6", 1, 0,0,0,0,0, 0,0,0,0,0);
    step("R6", 1, 0,0,1,0,0, 0,0,1,0,0);
    // R5 disabled port with write select high writes nothing
    step("R5", 1, 0,1,1,8'h05,16'hDEAD, 0,1,1,8'h09,16'hBEEF);
    step("R5", 1, 1,0,1,8'h05,0, 1,0,1,8'h09,0);
    step("R5", 1, 0,0,1,0,0, 0,0,1,0,0);
    // R3 same-address writes, left stored; R2 both read same word
    step("R3", 1, 1,1,1,8'h20,16'h1111, 1,1,1,8'h20,16'h2222);
    step("R2", 1, 1,0,1,8'h20,0, 1,0,1,8'h20,0);
    step("R3", 1, 0,0,1,0,0, 0,0,1,0,0);
    // R4 write racing a read: reader sees old word
    step("R4", 1, 1,1,1,8'h30,16'h0303, 0,0,1,0,0);
    step("R4", 1, 1,1,1,8'h30,16'h3333, 1,0,1,8'h30,0);
    step("R4", 1, 0,0,1,0,0, 1,0,1,8'h30,0);
    step("R4", 1, 0,0,1,0,0, 0,0,1,0,0);
    // R7 left writes right mailbox
    step("R7", 1, 1,1,1,BR,16'h7777, 0,0,1,0,0);
    step("R7", 1, 0,0,1,0,0, 0,0,1,0,0);
    // R10 left reads right mailbox, flags unchanged
    step("R10", 1, 1,0,1,BR,0, 0,0,1,0,0);
    step("R10", 1, 0,0,1,0,0, 0,0,1,0,0);
    // R9 right reads its own mailbox, release
    step("R9", 1, 0,0,1,0,0, 1,0,1,BR,0);
    step("R9", 1, 0,0,1,0,0, 0,0,1,0,0);
    // R8 right writes left mailbox
    step("R8", 1, 0,0,1,0,0, 1,1,1,BL,16'h8888);
    step("R8", 1, 0,0,1,0,0, 0,0,1,0,0);
    // R10 right reads left mailbox
    step("R10", 1, 0,0,1,0,0, 1,0,1,BL,0);
    // R11 left writes own mailbox while its flag is set
    step("R11", 1, 1,1,1,BL,16'hC0DE, 0,0,1,0,0);
    step("R11", 1, 0,0,1,0,0, 0,0,1,0,0);
    // R9 left reads own mailbox: new data, release
    step("R9", 1, 1,0,1,BL,0, 0,0,1,0,0);
    step("R9", 1, 0,0,1,0,0, 0,0,1,0,0);
    // R11 right writes own mailbox
    step("R11", 1, 0,0,1,0,0, 1,1,1,BR,16'h0B0B);
    step("R11", 1, 0,0,1,0,0, 1,0,1,BR,0);
    // R12 set and release of right flag in one cycle
    step("R12", 1, 1,1,1,BR,16'h1212, 1,0,1,BR,0);
    step("R12", 1, 0,0,1,0,0, 0,0,1,0,0);
    step("R9", 1, 0,0,1,0,0, 1,0,1,BR,0);
    step("R9", 1, 0,0,1,0,0, 0,0,1,0,0);
    // R13 reset again clears flag and read registers
    step("R13", 1, 0,0,1,0,0, 1,1,1,BL,16'h4444);
    step("R13", 0, 0,0,1,0,0, 0,0,1,0,0);
    step("R13", 1, 0,0,1,0,0, 0,0,1,0,0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule